// File: doc/BRIEF.md
# Branch Target Address Generator

This block works out the next program counter value for the jump instructions of a small microcontroller with a 14-bit code address. It handles five jump forms. The absolute form replaces the whole counter. The short relative form adds a signed displacement. The block-local form keeps the top two counter bits and takes the other twelve from the instruction. The two page-indirect forms keep the upper six bits and take the low byte from one of two 8-bit register pairs. Every splice and sum starts from the address of the byte after the jump instruction, which the fetch unit supplies.

The decoder raises a start strobe for one cycle, with a kind code and all operand fields. The block reports the number of machine cycles the form costs and captures the target on that edge. It then stays busy until the last cycle of the jump. The program counter register loads on that last cycle only, and a one-cycle valid strobe marks the load. The block drops any start that arrives while it is busy, and any start that carries an unused kind code.

Top module: `bta_gen`

## Requirements
- R1: After reset, `pc_q` equals parameter `RESET_PC` (default 0), and `busy` and `pc_valid` are both 0.
- R2: Kind code 0 (absolute) takes the target from `abs_addr` in full, and `cost_cycles` reports 3.
- R3: Kind code 1 (relative) gives the target as `pc_after` plus `rel_disp`, with `rel_disp` read as two's complement and the sum taken modulo 2^14. `cost_cycles` reports 2.
- R4: Kind code 2 (block-local) keeps `pc_after` bits 13..12 as target bits 13..12 and takes bits 11..0 from `blk_addr`. `cost_cycles` reports 2.
- R5: Kind code 3 (DE page) keeps `pc_after` bits 13..8 and takes bits 7..0 from `reg_de`. `cost_cycles` reports 3.
- R6: Kind code 4 (XA page) keeps `pc_after` bits 13..8 and takes bits 7..0 from `reg_xa`. `cost_cycles` reports 3.
- R7: Say a start is accepted at clock edge E and its kind costs N cycles. Then `pc_q` takes the target at edge E+N-1, and `pc_valid` is 1 for exactly the cycle after that edge. Between jumps `pc_q` holds its value. Operand inputs that change after edge E do not affect the target.
- R8: A start raised while `busy` is 1 has no effect. The jump in flight completes with its own target and timing.
- R9: Kind codes 5, 6 and 7 make `cost_cycles` report 0. A start that carries one of them is dropped: `busy` stays 0 and `pc_q` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| br_start | input | 1 | One-cycle strobe that issues a jump |
| br_kind | input | 3 | Jump form code (0 absolute, 1 relative, 2 block, 3 DE page, 4 XA page) |
| pc_after | input | PC_W | Address of the byte after the jump instruction |
| abs_addr | input | PC_W | Full target for the absolute form |
| rel_disp | input | DISP_W | Signed displacement for the relative form |
| blk_addr | input | BLK_W | Low field for the block-local form |
| reg_de | input | PAGE_W | DE register pair contents |
| reg_xa | input | PAGE_W | XA register pair contents |
| cost_cycles | output | 2 | Machine cycles of the presented kind; 0 for unused codes |
| busy | output | 1 | A jump is in flight |
| pc_q | output | PC_W | Program counter register |
| pc_valid | output | 1 | One-cycle strobe: `pc_q` has just loaded a target |

## Verification
The bench uses the default parameters: a 14-bit counter, an 8-bit displacement, a 12-bit block field and an 8-bit page. With these widths, random starting addresses near both ends of the code space and displacements of either sign make the relative sum wrap past 0x3FFF and past 0. Random upper counter bits check that the block-local and page forms preserve the bits they are meant to keep. The 8-bit displacement is narrower than the counter, so the sign-extension branch of the adder is the one built. Both the 2-cycle and the 3-cycle timings are exercised, with extra starts and changing operands injected while a jump is busy.

// File: rtl/bta_pkg.sv
// Shared definitions for the branch target generator.
// Assumes the kind codes are produced by an external decoder.
package bta_pkg;
    localparam int COST_W = 2;

    typedef enum logic [2:0] {
        BK_ABS = 3'd0,
        BK_REL = 3'd1,
        BK_BLK = 3'd2,
        BK_DE  = 3'd3,
        BK_XA  = 3'd4
    } br_kind_e;

    localparam logic [COST_W-1:0] CYC_ABS  = 2'd3;
    localparam logic [COST_W-1:0] CYC_REL  = 2'd2;
    localparam logic [COST_W-1:0] CYC_BLK  = 2'd2;
    localparam logic [COST_W-1:0] CYC_PAGE = 2'd3;
endpackage

// File: rtl/bta_target.sv
// Combinational target computation for every jump form.
// Assumes BLK_W and PAGE_W are below PC_W. pc_after is the address
// that follows the jump instruction.
module bta_target
    import bta_pkg::*;
#(
    parameter int PC_W   = 14,
    parameter int DISP_W = 8,
    parameter int BLK_W  = 12,
    parameter int PAGE_W = 8
) (
    input  logic [2:0]        kind,
    input  logic [PC_W-1:0]   pc_after,
    input  logic [PC_W-1:0]   abs_addr,
    input  logic [DISP_W-1:0] rel_disp,
    input  logic [BLK_W-1:0]  blk_addr,
    input  logic [PAGE_W-1:0] reg_de,
    input  logic [PAGE_W-1:0] reg_xa,
    output logic [PC_W-1:0]   target
);
    logic [PC_W-1:0]   disp_ext;
    logic [PAGE_W-1:0] page_low;

    // Widen or trim the displacement to the counter width.
    generate
        if (DISP_W < PC_W) begin : g_sext
            assign disp_ext = {{(PC_W-DISP_W){rel_disp[DISP_W-1]}}, rel_disp};
        end else begin : g_trim
            assign disp_ext = rel_disp[PC_W-1:0];
        end
    endgenerate

    // Choose the register pair that supplies the low byte.
    assign page_low = (kind == BK_DE) ? reg_de : reg_xa;

    // Build the target for the presented kind.
    always_comb begin
        case (kind)
            BK_ABS:       target = abs_addr;
            BK_REL:       target = pc_after + disp_ext;
            BK_BLK:       target = {pc_after[PC_W-1:BLK_W], blk_addr};
            BK_DE, BK_XA: target = {pc_after[PC_W-1:PAGE_W], page_low};
            default:      target = pc_after;
        endcase
    end
endmodule

// File: rtl/bta_cost.sv
// Maps a jump kind to its fixed machine-cycle cost.
// Assumes unused codes must cost 0 so the sequencer can reject them.
module bta_cost
    import bta_pkg::*;
(
    input  logic [2:0]        kind,
    output logic [COST_W-1:0] cost,
    output logic              kind_ok
);
    // Look up the cycle cost of each form.
    always_comb begin
        case (kind)
            BK_ABS:       cost = CYC_ABS;
            BK_REL:       cost = CYC_REL;
            BK_BLK:       cost = CYC_BLK;
            BK_DE, BK_XA: cost = CYC_PAGE;
            default:      cost = '0;
        endcase
    end

    // A kind is usable when it carries a nonzero cost.
    assign kind_ok = (cost != '0);
endmodule

// File: rtl/bta_seq.sv
// Cycle sequencer: captures the target when a jump starts, counts
// down its cost and loads the counter register on its last cycle.
// Assumes every valid cost is at least 2.
module bta_seq
    import bta_pkg::*;
#(
    parameter int               PC_W     = 14,
    parameter logic [PC_W-1:0]  RESET_PC = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              kind_ok,
    input  logic [COST_W-1:0] cost,
    input  logic [PC_W-1:0]   target,
    output logic              busy,
    output logic [PC_W-1:0]   pc_q,
    output logic              pc_valid
);
    logic [COST_W-1:0] remain;
    logic [PC_W-1:0]   held;

    // Count the remaining cycles and load the counter at the end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain   <= '0;
            held     <= RESET_PC;
            pc_q     <= RESET_PC;
            pc_valid <= 1'b0;
        end else begin
            pc_valid <= 1'b0;
            if (remain != '0) begin
                remain <= remain - 1'b1;
                if (remain == 1) begin
                    pc_q     <= held;
                    pc_valid <= 1'b1;
                end
            end else if (start && kind_ok) begin
                held   <= target;
                remain <= cost - 1'b1;
            end
        end
    end

    // The block is busy while cycles remain.
    assign busy = (remain != '0);
endmodule

// File: rtl/bta_gen.sv
// Top of the branch target generator: joins the target computation,
// the cost lookup and the sequencer.
// Assumes the decoder holds br_start for one cycle per jump.
module bta_gen
    import bta_pkg::*;
#(
    parameter int              PC_W     = 14,
    parameter int              DISP_W   = 8,
    parameter int              BLK_W    = 12,
    parameter int              PAGE_W   = 8,
    parameter logic [PC_W-1:0] RESET_PC = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              br_start,
    input  logic [2:0]        br_kind,
    input  logic [PC_W-1:0]   pc_after,
    input  logic [PC_W-1:0]   abs_addr,
    input  logic [DISP_W-1:0] rel_disp,
    input  logic [BLK_W-1:0]  blk_addr,
    input  logic [PAGE_W-1:0] reg_de,
    input  logic [PAGE_W-1:0] reg_xa,
    output logic [1:0]        cost_cycles,
    output logic              busy,
    output logic [PC_W-1:0]   pc_q,
    output logic              pc_valid
);
    logic [PC_W-1:0]   tgt;
    logic [COST_W-1:0] cost;
    logic              kind_ok;

    bta_target #(
        .PC_W(PC_W), .DISP_W(DISP_W), .BLK_W(BLK_W), .PAGE_W(PAGE_W)
    ) u_target (
        .kind(br_kind), .pc_after(pc_after), .abs_addr(abs_addr),
        .rel_disp(rel_disp), .blk_addr(blk_addr), .reg_de(reg_de),
        .reg_xa(reg_xa), .target(tgt)
    );

    bta_cost u_cost (
        .kind(br_kind), .cost(cost), .kind_ok(kind_ok)
    );

    bta_seq #(
        .PC_W(PC_W), .RESET_PC(RESET_PC)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .start(br_start), .kind_ok(kind_ok),
        .cost(cost), .target(tgt), .busy(busy), .pc_q(pc_q),
        .pc_valid(pc_valid)
    );

    assign cost_cycles = cost;
endmodule

// File: rtl/bta_gen_chk.sv
// Protocol checker for bta_gen, attached through bind.
// Assumes reset is asserted from time zero.
module bta_gen_chk #(
    parameter int PC_W = 14
) (
    input logic            clk,
    input logic            rst_n,
    input logic            br_start,
    input logic [2:0]      br_kind,
    input logic            busy,
    input logic [PC_W-1:0] pc_q,
    input logic            pc_valid
);
    // R7: the counter register moves only together with the strobe.
    a_r7_pc_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !pc_valid |-> $stable(pc_q));

    // R7: the valid strobe lasts a single cycle.
    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        pc_valid |=> !pc_valid);

    // R7: the load happens on the final cycle, so busy has already cleared.
    a_r7_idle_on_load: assert property (@(posedge clk) disable iff (!rst_n)
        pc_valid |-> !busy);

    // R8: a busy jump never ends without loading the counter.
    a_r8_busy_ends_in_load: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (busy || pc_valid));

    // R9: an unused kind code never starts a jump.
    a_r9_bad_kind_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (br_start && !busy && br_kind > 3'd4) |=> !busy);
endmodule

bind bta_gen bta_gen_chk #(.PC_W(PC_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .br_start(br_start), .br_kind(br_kind),
    .busy(busy), .pc_q(pc_q), .pc_valid(pc_valid)
);

// File: tb/tb_bta_gen.sv
`timescale 1ns/1ps
// Self-checking bench for bta_gen: directed corners plus seeded random jumps.
module tb_bta_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        br_start = 1'b0;
    logic [2:0]  br_kind = '0;
    logic [13:0] pc_after = '0, abs_addr = '0;
    logic [7:0]  rel_disp = '0;
    logic [11:0] blk_addr = '0;
    logic [7:0]  reg_de = '0, reg_xa = '0;
    logic [1:0]  cost_cycles;
    logic        busy, pc_valid;
    logic [13:0] pc_q;

    int total = 0, bad = 0;
    logic [13:0] exp_pc = '0;

    always #2.5 clk = ~clk;

    bta_gen dut (.*);

    // Record one check and report a mismatch.
    task automatic check(input bit ok, input string req, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // Expected target derived from the requirement text.
    function automatic logic [13:0] model_tgt(input logic [2:0] k, input logic [13:0] pa,
        input logic [13:0] ab, input logic [7:0] d, input logic [11:0] bl,
        input logic [7:0] de, input logic [7:0] xa);
        int s;
        case (k)
            3'd0: return ab;
            3'd1: begin s = int'(pa) + int'($signed(d)); return 14'(s & 32'h3fff); end
            3'd2: return {pa[13:12], bl};
            3'd3: return {pa[13:8], de};
            3'd4: return {pa[13:8], xa};
            default: return pa;
        endcase
    endfunction

    // Expected cycle cost of each kind.
    function automatic int model_cost(input logic [2:0] k);
        case (k)
            3'd0, 3'd3, 3'd4: return 3;
            3'd1, 3'd2: return 2;
            default: return 0;
        endcase
    endfunction

    function automatic string req_of(input logic [2:0] k);
        case (k)
            3'd0: return "R2";
            3'd1: return "R3";
            3'd2: return "R4";
            3'd3: return "R5";
            3'd4: return "R6";
            default: return "R9";
        endcase
    endfunction

    // Issue one jump and follow it cycle by cycle; optionally inject a start while busy.
    task automatic run_jump(input logic [2:0] k, input logic [13:0] pa, input logic [13:0] ab,
        input logic [7:0] d, input logic [11:0] bl, input logic [7:0] de, input logic [7:0] xa,
        input bit intrude);
        logic [13:0] tgt;
        int n;
        tgt = model_tgt(k, pa, ab, d, bl, de, xa);
        n = model_cost(k);
        @(negedge clk);
        br_kind = k; pc_after = pa; abs_addr = ab; rel_disp = d;
        blk_addr = bl; reg_de = de; reg_xa = xa; br_start = 1'b1;
        #1;
        check(cost_cycles == 2'(n), req_of(k), cost_cycles, n);
        @(negedge clk);
        // R7: later operand changes must not move the captured target
        br_start = intrude;   // R8: extra start while busy
        br_kind = 3'($urandom_range(0, 4));
        pc_after = 14'($urandom); abs_addr = 14'($urandom); rel_disp = 8'($urandom);
        blk_addr = 12'($urandom); reg_de = 8'($urandom); reg_xa = 8'($urandom);
        check(busy == 1'b1 && pc_q == exp_pc, "R7", pc_q, exp_pc);
        for (int i = 1; i < n; i++) begin
            @(negedge clk);
            br_start = 1'b0;
            if (i < n - 1)
                check(pc_q == exp_pc && !pc_valid, "R7", pc_q, exp_pc);
            else begin
                check(pc_q == tgt, req_of(k), pc_q, tgt);
                check(pc_valid == 1'b1 && busy == 1'b0, "R7", {pc_valid, busy}, 2'b10);
            end
        end
        exp_pc = tgt;
        @(negedge clk);
        check(pc_valid == 1'b0 && pc_q == exp_pc, intrude ? "R8" : "R7", pc_q, exp_pc);
        check(busy == 1'b0, intrude ? "R8" : "R7", busy, 0);
    endtask

    // Present an unused kind with a start and confirm it is dropped.
    task automatic run_bad(input logic [2:0] k);
        @(negedge clk);
        br_kind = k; pc_after = 14'($urandom); br_start = 1'b1;
        #1;
        check(cost_cycles == 2'd0, "R9", cost_cycles, 0);
        @(negedge clk);
        br_start = 1'b0;
        check(busy == 1'b0, "R9", busy, 0);
        repeat (2) @(negedge clk);
        check(pc_q == exp_pc && !pc_valid, "R9", pc_q, exp_pc);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(5.0 * 190000);
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [13:0] pa;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        // R1: reset state
        check(pc_q == 14'd0 && !busy && !pc_valid, "R1", pc_q, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(pc_q == 14'd0 && !busy && !pc_valid, "R1", pc_q, 0);

        // Directed corners
        run_jump(3'd0, 14'h0100, 14'h3fff, 8'h00, 12'h000, 8'h00, 8'h00, 1'b0);
        run_jump(3'd1, 14'h3ffe, 14'h0000, 8'h05, 12'h000, 8'h00, 8'h00, 1'b0); // R3 wrap up -> 0003
        run_jump(3'd1, 14'h0002, 14'h0000, 8'hfc, 12'h000, 8'h00, 8'h00, 1'b0); // R3 wrap down -> 3ffe
        run_jump(3'd1, 14'h1234, 14'h0000, 8'h80, 12'h000, 8'h00, 8'h00, 1'b0); // R3 most negative
        run_jump(3'd2, 14'h3abc, 14'h0000, 8'h00, 12'h001, 8'h00, 8'h00, 1'b0); // R4
        run_jump(3'd3, 14'h2f00, 14'h0000, 8'h00, 12'h000, 8'hff, 8'h11, 1'b0); // R5
        run_jump(3'd4, 14'h15aa, 14'h0000, 8'h00, 12'h000, 8'h22, 8'h00, 1'b0); // R6
        run_jump(3'd0, 14'h0000, 14'h2aaa, 8'h00, 12'h000, 8'h00, 8'h00, 1'b1); // R8
        run_jump(3'd1, 14'h0040, 14'h0000, 8'h10, 12'h000, 8'h00, 8'h00, 1'b1); // R8 short form
        run_bad(3'd5);
        run_bad(3'd6);
        run_bad(3'd7);

        // Random jumps, with pc_after biased toward the ends of the space
        for (int it = 0; it < 400; it++) begin
            case ($urandom_range(0, 3))
                0: pa = 14'($urandom_range(0, 15));
                1: pa = 14'h3fff - 14'($urandom_range(0, 15));
                default: pa = 14'($urandom);
            endcase
            if ($urandom_range(0, 19) == 0)
                run_bad(3'($urandom_range(5, 7)));
            else
                run_jump(3'($urandom_range(0, 4)), pa, 14'($urandom), 8'($urandom),
                         12'($urandom), 8'($urandom), 8'($urandom), 1'($urandom));
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule